// File: doc/BRIEF.md
# Switchable Processor Clock Divider

This block turns one master clock into the set of slower clocks a small computer board needs. Two of them have fixed ratios. A video reference runs at half the master rate, and a serial baud reference runs at a quarter of the master rate. Both are registered in the master clock domain. The third output is the processor clock. A speed-select level picks its ratio: divide-by-10 when the level is low and divide-by-5 when it is high. At a 20.2752 MHz master these give about 2.03 MHz and about 4.055 MHz.

A divide-by-5 cannot be symmetric when it counts master edges. The processor clock is therefore counted on an oversampling clock at twice the master rate. Each phase lasts 10 oversample ticks when slow and 5 ticks when fast, so every phase is at least 5 ticks long (about 123 ns against a 110 ns floor). The speed-select level passes through a two-flop synchroniser. The ratio it selects is adopted only at a falling edge of the processor clock, so the cycle in progress always finishes both of its phases at the old ratio.

The integrator feeds the master clock and the oversampling clock, which have aligned rising edges. The integrator also provides a synchronous active-high reset and the speed-select level, then routes the three registered levels to their consumers.

Top module: `sysclk_divider`

## Requirements
- R1: While reset is high, all three outputs are driven low from the next edge of their own clock, and every counter returns to zero.
- R2: The video output toggles on every master rising edge after reset. It is high after the first master edge that follows reset release, so its period is 2 master cycles with equal phases.
- R3: The baud output has a period of 4 master cycles: 2 high and 2 low. It first goes high after the second master edge that follows reset release, and it changes only when the video output falls.
- R4: With the ratio slow (speed-select low), each processor-clock phase lasts exactly 10 oversample ticks. After reset release the ratio is slow and the output first rises on the 10th oversample rising edge.
- R5: With the ratio fast (speed-select high), each processor-clock phase lasts exactly 5 oversample ticks.
- R6: No processor-clock phase is ever shorter than 5 oversample ticks, including phases next to a speed change.
- R7: A new ratio takes effect only at a processor-clock falling edge. The high phase of a cycle always has the same length as the low phase just before it. When speed-select changes just after a falling edge, the current cycle completes at the old ratio and the following cycle uses the new one.
- R8: Speed-select passes through two flip-flops before use. A change presented 3 oversample edges before a falling edge is adopted at that edge. A change presented 2 edges before is not adopted there, but is adopted at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock |
| osclk_i | input | 1 | Oversampling clock at twice the master rate, rising edges aligned with the master |
| rst_i | input | 1 | Synchronous active-high reset |
| fast_i | input | 1 | Speed select: 1 = divide-by-5, 0 = divide-by-10 (asynchronous) |
| vid_clk_o | output | 1 | Video reference, master / 2 |
| baud_clk_o | output | 1 | Baud reference, master / 4 |
| pclk_o | output | 1 | Processor clock, master / 10 or master / 5 |

## Verification
The bench changes speed-select at several points in the processor-clock cycle. A change made right after a falling edge must leave one whole cycle at the old ratio. A design that adopted the change at once would emit a short, lopsided cycle, and one that switched mid-phase would produce a runt. Changes made 3 and 2 oversample edges before a falling edge tell a correct two-flop synchroniser apart from one with a single flop or none, since those would adopt the late change one cycle early. Exact edge counts after reset release catch a divider that starts at the wrong phase, and a reset asserted in mid-run checks that every output drops low.

// File: rtl/sysclk_divider_pkg.sv
package sysclk_divider_pkg;

    // Phase lengths of the processor clock, in oversample ticks
    localparam int unsigned OS_HALF_SLOW = 10;
    localparam int unsigned OS_HALF_FAST = 5;

    // Fixed dividers: log2 of the ratio against the master clock
    localparam int unsigned VIDEO_LOG2 = 1;
    localparam int unsigned BAUD_LOG2  = 2;

    // Stages in the speed-select synchroniser
    localparam int unsigned SEL_SYNC_STAGES = 2;

    typedef enum logic {
        SPD_SLOW = 1'b0,
        SPD_FAST = 1'b1
    } speed_e;

    function automatic int unsigned phase_ticks(speed_e s, int unsigned slow_n, int unsigned fast_n);
        return (s == SPD_FAST) ? fast_n : slow_n;
    endfunction

endpackage

// File: rtl/sel_sync_chain.sv
module sel_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) stg <= '0;
                else       stg <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) stg <= '0;
                else       stg <= {stg[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int unsigned LOG2 = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic level_o
);
    logic [LOG2-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt <= '0;
        else       cnt <= cnt + 1'b1;
    end

    // Top bit of a power-of-two counter: equal high and low phases
    assign level_o = cnt[LOG2-1];
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import sysclk_divider_pkg::*;
#(
    parameter int unsigned HALF_SLOW = OS_HALF_SLOW,
    parameter int unsigned HALF_FAST = OS_HALF_FAST
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fast_sync_i,
    output logic pclk_o
);
    localparam int unsigned HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int unsigned CW       = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;
    localparam logic [CW-1:0] LAST_SLOW = CW'(HALF_SLOW - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'(HALF_FAST - 1);

    typedef struct packed {
        logic [CW-1:0] tick;   // ticks spent in the current phase
        logic          level;  // output level
        speed_e        speed;  // ratio in force for this cycle
    } pclk_state_t;

    pclk_state_t cur, nxt;
    logic [CW-1:0] last_tick;

    always_comb begin
        last_tick = (cur.speed == SPD_FAST) ? LAST_FAST : LAST_SLOW;
        nxt = cur;
        if (cur.tick == last_tick) begin
            nxt.tick  = '0;
            nxt.level = ~cur.level;
            // Adopt a new ratio only as the output falls
            if (cur.level) nxt.speed = speed_e'(fast_sync_i);
        end else begin
            nxt.tick = cur.tick + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cur <= '{tick: '0, level: 1'b0, speed: SPD_SLOW};
        else       cur <= nxt;
    end

    assign pclk_o = cur.level;
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import sysclk_divider_pkg::*;
#(
    parameter int unsigned VIDEO_DIV_LOG2 = VIDEO_LOG2,
    parameter int unsigned BAUD_DIV_LOG2  = BAUD_LOG2,
    parameter int unsigned HALF_SLOW      = OS_HALF_SLOW,
    parameter int unsigned HALF_FAST      = OS_HALF_FAST,
    parameter int unsigned SYNC_STAGES    = SEL_SYNC_STAGES
) (
    input  logic mclk_i,
    input  logic osclk_i,
    input  logic rst_i,
    input  logic fast_i,
    output logic vid_clk_o,
    output logic baud_clk_o,
    output logic pclk_o
);
    localparam int unsigned NUM_FIXED = 2;
    localparam int unsigned FIX_LOG2 [NUM_FIXED] = '{VIDEO_DIV_LOG2, BAUD_DIV_LOG2};

    logic [NUM_FIXED-1:0] fixed_lvl;
    logic                 fast_sync;

    generate
        for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
            ratio_divider #(.LOG2(FIX_LOG2[g])) u_div (
                .clk_i   (mclk_i),
                .rst_i   (rst_i),
                .level_o (fixed_lvl[g])
            );
        end
    endgenerate

    assign vid_clk_o  = fixed_lvl[0];
    assign baud_clk_o = fixed_lvl[1];

    sel_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (osclk_i),
        .rst_i (rst_i),
        .d_i   (fast_i),
        .q_o   (fast_sync)
    );

    pclk_gen #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_pclk (
        .clk_i       (osclk_i),
        .rst_i       (rst_i),
        .fast_sync_i (fast_sync),
        .pclk_o      (pclk_o)
    );
endmodule

// File: rtl/sysclk_divider_chk.sv
module sysclk_divider_chk #(
    parameter int unsigned HALF_SLOW = 10,
    parameter int unsigned HALF_FAST = 5,
    parameter int unsigned MIN_PHASE = 5
) (
    input logic mclk_i,
    input logic osclk_i,
    input logic rst_i,
    input logic vid_clk_o,
    input logic baud_clk_o,
    input logic pclk_o
);
    localparam logic [7:0] L_SLOW = 8'(HALF_SLOW);
    localparam logic [7:0] L_FAST = 8'(HALF_FAST);
    localparam logic [7:0] L_MIN  = 8'(MIN_PHASE);

    logic       m_rst_d;
    logic       last_lvl;
    logic       low_valid;
    logic [7:0] run_len;
    logic [7:0] low_len;
    logic       edge_seen;

    always_ff @(posedge mclk_i) m_rst_d <= rst_i;

    assign edge_seen = (pclk_o != last_lvl);

    always_ff @(posedge osclk_i) begin
        if (rst_i) begin
            last_lvl  <= 1'b0;
            run_len   <= '0;
            low_len   <= '0;
            low_valid <= 1'b0;
        end else if (edge_seen) begin
            last_lvl <= pclk_o;
            run_len  <= 8'd1;
            if (!last_lvl) begin
                low_len   <= run_len;
                low_valid <= 1'b1;
            end
        end else if (run_len != 8'hFF) begin
            run_len <= run_len + 8'd1;
        end
    end

    a_r1_pclk_reset_low: assert property (@(posedge osclk_i)
        rst_i |=> !pclk_o)
        else $error("a_r1_pclk_reset_low");

    a_r1_fixed_reset_low: assert property (@(posedge mclk_i)
        rst_i |=> (!vid_clk_o && !baud_clk_o))
        else $error("a_r1_fixed_reset_low");

    a_r2_video_toggles: assert property (@(posedge mclk_i) disable iff (rst_i || m_rst_d)
        vid_clk_o != $past(vid_clk_o))
        else $error("a_r2_video_toggles");

    a_r3_baud_holds: assert property (@(posedge mclk_i) disable iff (rst_i || m_rst_d)
        (baud_clk_o != $past(baud_clk_o)) |=> (baud_clk_o == $past(baud_clk_o)))
        else $error("a_r3_baud_holds");

    a_r3_baud_on_video_fall: assert property (@(posedge mclk_i) disable iff (rst_i || m_rst_d)
        (baud_clk_o != $past(baud_clk_o)) |-> (!vid_clk_o && $past(vid_clk_o)))
        else $error("a_r3_baud_on_video_fall");

    a_r5_phase_length: assert property (@(posedge osclk_i) disable iff (rst_i)
        edge_seen |-> (run_len == L_SLOW || run_len == L_FAST))
        else $error("a_r5_phase_length");

    a_r6_min_phase: assert property (@(posedge osclk_i) disable iff (rst_i)
        edge_seen |-> (run_len >= L_MIN))
        else $error("a_r6_min_phase");

    a_r7_symmetric: assert property (@(posedge osclk_i) disable iff (rst_i)
        (edge_seen && last_lvl && low_valid) |-> (run_len == low_len))
        else $error("a_r7_symmetric");
endmodule

bind sysclk_divider sysclk_divider_chk #(
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST),
    .MIN_PHASE (5)
) u_chk (
    .mclk_i     (mclk_i),
    .osclk_i    (osclk_i),
    .rst_i      (rst_i),
    .vid_clk_o  (vid_clk_o),
    .baud_clk_o (baud_clk_o),
    .pclk_o     (pclk_o)
);

// File: tb/sysclk_divider_test.sv
module sysclk_divider_test;
    logic osclk = 1'b0;
    logic mclk  = 1'b0;
    logic rst   = 1'b1;
    logic fast  = 1'b0;
    logic vid, baud, pclk;

    int total = 0;
    int bad   = 0;

    // Each entry: {speed select, expected phase length in oversample ticks}
    localparam int NVEC = 8;
    localparam logic [4:0] VEC [NVEC] = '{
        {1'b1, 4'd5}, {1'b1, 4'd5}, {1'b0, 4'd10}, {1'b1, 4'd5},
        {1'b0, 4'd10}, {1'b0, 4'd10}, {1'b1, 4'd5}, {1'b0, 4'd10}
    };

    always #5 osclk = ~osclk;                 // 100 MHz oversampling clock
    always @(posedge osclk) mclk <= ~mclk;    // master at half rate

    sysclk_divider uut (
        .mclk_i     (mclk),
        .osclk_i    (osclk),
        .rst_i      (rst),
        .fast_i     (fast),
        .vid_clk_o  (vid),
        .baud_clk_o (baud),
        .pclk_o     (pclk)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedge samples at level lvl, starting from the current sample
    task automatic measure(input logic lvl, output int n);
        n = 0;
        while (pclk === lvl && n < 100) begin
            n++;
            @(negedge osclk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge osclk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, l1, h1, l2, h2, k, old_half, new_half;

        // R1: reset state
        repeat (6) @(negedge osclk);
        check("R1 vid in reset", int'(vid), 0);
        check("R1 baud in reset", int'(baud), 0);
        check("R1 pclk in reset", int'(pclk), 0);

        // R2 / R3: fixed dividers, release just before a master rising edge
        @(negedge mclk);
        @(negedge osclk);
        rst = 1'b0;
        for (int j = 1; j <= 12; j++) begin
            @(posedge mclk);
            @(negedge osclk);
            check("R2 video level", int'(vid), j % 2);
            check("R3 baud level", int'(baud), ((j % 4) >= 2) ? 1 : 0);
        end

        // R1 again, then R4: start of processor clock after release
        @(negedge osclk);
        rst = 1'b1;
        repeat (4) @(negedge osclk);
        check("R1 pclk reset again", int'(pclk), 0);
        check("R1 vid reset again", int'(vid), 0);
        rst = 1'b0;
        k = 0;
        for (int i = 1; i <= 40; i++) begin
            @(posedge osclk);
            @(negedge osclk);
            if (pclk === 1'b1) begin
                k = i;
                break;
            end
        end
        check("R4 first rise edge", k, 10);
        measure(1'b1, n); check("R4 first high", n, 10);
        measure(1'b0, n); check("R4 slow low", n, 10);
        while (pclk === 1'b1) @(negedge osclk);

        // R7 / R4 / R5: vector walk, change applied at first low sample
        old_half = 10;
        for (int i = 0; i < NVEC; i++) begin
            fast = VEC[i][4];
            new_half = int'(VEC[i][3:0]);
            measure(1'b0, l1); measure(1'b1, h1);
            measure(1'b0, l2); measure(1'b1, h2);
            check("R7 old ratio low kept", l1, old_half);
            check("R7 old ratio high kept", h1, old_half);
            if (new_half == 5) begin
                check("R5 fast low", l2, 5);
                check("R5 fast high", h2, 5);
            end else begin
                check("R4 slow low", l2, 10);
                check("R4 slow high", h2, 10);
            end
            check("R6 no short phase", (l2 >= 5 && h2 >= 5) ? 1 : 0, 1);
            old_half = new_half;
        end

        // R8: change 2 edges before a fall is not adopted there (ratio now slow)
        measure(1'b0, n);
        repeat (8) @(negedge osclk);
        fast = 1'b1;
        measure(1'b1, n);
        measure(1'b0, l1); measure(1'b1, h1);
        check("R8 late change not adopted low", l1, 10);
        check("R8 late change not adopted high", h1, 10);
        measure(1'b0, l2); measure(1'b1, h2);
        check("R8 adopted next fall low", l2, 5);
        check("R8 adopted next fall high", h2, 5);

        // R8: change 3 edges before a fall is adopted at that fall
        measure(1'b0, n);
        check("R5 fast low before test", n, 5);
        repeat (2) @(negedge osclk);
        fast = 1'b0;
        measure(1'b1, n);
        measure(1'b0, l1); measure(1'b1, h1);
        check("R8 early change adopted low", l1, 10);
        check("R8 early change adopted high", h1, 10);

        // R1: reset in mid-run
        repeat (3) @(negedge osclk);
        rst = 1'b1;
        repeat (3) @(negedge osclk);
        check("R1 mid-run pclk", int'(pclk), 0);
        check("R1 mid-run vid", int'(vid), 0);
        check("R1 mid-run baud", int'(baud), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule